// File: doc/BRIEF.md
# Sound Unit Diagnostic Register Window

This block sits beside a sound generator on an 8-bit CPU bus and opens a small diagnostic window inside the sound unit's 32-byte register page. When the test-enable input is high, three read offsets return the live digital output levels of every channel. The two square channels, the noise channel and the triangle channel are 4 bits each, packed two per byte. The delta-sample channel is 7 bits wide. One write offset forces the triangle sequencer to a chosen step and can freeze all channels.

The block also drives the bus-isolation signal. This signal disconnects the external data bus from the internal bus during page reads. The status offset always isolates. In test mode every offset of the page isolates, which hides the controller-port offsets from the CPU. It also gates the bus clock output while reset is held: the clock keeps running only when test mode is on.

Top module: `snd_tm_regwin`

## Requirements
- R1: With test_en high, a read (page_sel, rd_en) at offset 0x18 sets rd_valid in the next cycle, and rdata = {sq2_dac, sq1_dac}, with pulse-2 in bits 7:4 and pulse-1 in bits 3:0.
- R2: With test_en high, a read at offset 0x19 returns, one cycle later, rdata = {noi_dac, tri_dac}, with noise in bits 7:4 and triangle in bits 3:0, and rd_valid high.
- R3: With test_en high, a read at offset 0x1A returns, one cycle later, the delta-sample level in bits 6:0 with bit 7 zero, and rd_valid high.
- R4: With test_en high, a write (page_sel, wr_en) at offset 0x1A sets tri_step to wdata[4:0] and freeze to wdata[7] from the next cycle. It also raises tri_load for exactly that one cycle. wdata[6:5] have no effect.
- R5: bus_isolate is high, in the same cycle, for a page read at offset 0x15 regardless of test_en, and for a page read at any offset when test_en is high. It is low otherwise.
- R6: Page reads at the controller offsets 0x16 and 0x17 raise bus_isolate when test_en is high and leave it low when test_en is low.
- R7: With test_en low, reads at 0x18–0x1A leave rd_valid low and rdata zero, and writes at 0x1A leave freeze, tri_step and tri_load unchanged.
- R8: m2_out follows m2_src while rst_n is high. While rst_n is low, m2_out follows m2_src if test_en is high and is held low if test_en is low.
- R9: A cycle with rst_n low clears freeze, tri_step, tri_load, rd_valid and rdata in the following cycle.
- R10: With page_sel low, no read raises bus_isolate or rd_valid, and no write changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, also the CPU reset level |
| test_en | input | 1 | Diagnostic mode enable |
| m2_src | input | 1 | Internally generated bus clock |
| page_sel | input | 1 | Access targets the sound register page |
| addr | input | 5 | Offset within the page |
| rd_en | input | 1 | Read cycle qualifier |
| wr_en | input | 1 | Write cycle qualifier |
| wdata | input | 8 | Write data |
| sq1_dac | input | 4 | Square 1 output level |
| sq2_dac | input | 4 | Square 2 output level |
| tri_dac | input | 4 | Triangle output level |
| noi_dac | input | 4 | Noise output level |
| dlt_dac | input | 7 | Delta-sample output level |
| rdata | output | 8 | Diagnostic read data, zero unless rd_valid |
| rd_valid | output | 1 | rdata holds a diagnostic read result |
| bus_isolate | output | 1 | Disconnect external data bus for this read |
| tri_step | output | 5 | Forced triangle sequencer step |
| tri_load | output | 1 | One-cycle strobe to load tri_step |
| freeze | output | 1 | Hold all channels (lock flag) |
| m2_out | output | 1 | Bus clock driven to the pins |

## Verification
Two functions can act in the same cycle. A diagnostic read and a diagnostic write can both be qualified on one edge. A held reset also interacts with test mode, both on the bus clock gate and on the register clear. The random stimulus raises rd_en and wr_en independently and pulls reset low at random points while test_en keeps changing, so reads of 0x1A can coincide with writes to it. Each cycle is judged against a bench model. In that model the read result, the sequencer force and the reset clear are computed separately, so a design that lets one function block another is caught.

// File: rtl/snd_tm_pkg.sv
// Package: offsets and widths shared by the diagnostic register window.
package snd_tm_pkg;
    localparam int AW       = 5;
    localparam int DW       = 8;
    localparam int VOL_W    = 4;
    localparam int DLT_W    = 7;
    localparam int STEP_W   = 5;
    localparam int LOCK_BIT = 7;

    localparam logic [AW-1:0] OFS_STATUS = 5'h15;
    localparam logic [AW-1:0] OFS_LVL_SQ = 5'h18;
    localparam logic [AW-1:0] OFS_LVL_NT = 5'h19;
    localparam logic [AW-1:0] OFS_LVL_DS = 5'h1A;

    // One-hot read selection for the three diagnostic read offsets.
    typedef enum logic [2:0] {
        RSEL_NONE = 3'b000,
        RSEL_SQ   = 3'b001,
        RSEL_NT   = 3'b010,
        RSEL_DS   = 3'b100
    } rsel_e;
endpackage

// File: rtl/snd_tm_decode.sv
// Address decoder: qualifies page accesses, selects the diagnostic read
// source, flags the diagnostic write, and computes bus isolation.
// Assumes addr is only meaningful while page_sel is high.
module snd_tm_decode
    import snd_tm_pkg::*;
(
    input  logic          test_en,
    input  logic          page_sel,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    output rsel_e         rd_sel,
    output logic          wr_hit,
    output logic          isolate
);
    logic page_rd;
    logic page_wr;

    // Qualify the access with the page select.
    always_comb begin
        page_rd = page_sel && rd_en;
        page_wr = page_sel && wr_en;
    end

    // Choose which diagnostic read source, if any, is addressed.
    always_comb begin
        rd_sel = RSEL_NONE;
        if (page_rd && test_en) begin
            unique case (addr)
                OFS_LVL_SQ: rd_sel = RSEL_SQ;
                OFS_LVL_NT: rd_sel = RSEL_NT;
                OFS_LVL_DS: rd_sel = RSEL_DS;
                default:    rd_sel = RSEL_NONE;
            endcase
        end
    end

    // Diagnostic write and bus isolation decode.
    always_comb begin
        wr_hit  = page_wr && test_en && (addr == OFS_LVL_DS);
        isolate = page_rd && (test_en || (addr == OFS_STATUS));
    end

    always_comb begin
        if (!page_sel) p_no_page_r10: assert (!isolate && !wr_hit && rd_sel == RSEL_NONE);
        if (rd_sel != RSEL_NONE) p_sel_isolates_r5: assert (isolate);
    end
endmodule

// File: rtl/snd_tm_rdmux.sv
// Read path: packs the live channel levels for the selected diagnostic
// offset into a registered read word. Assumes rd_sel is one-hot or zero.
module snd_tm_rdmux
    import snd_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  rsel_e            rd_sel,
    input  logic [VOL_W-1:0] sq1_dac,
    input  logic [VOL_W-1:0] sq2_dac,
    input  logic [VOL_W-1:0] tri_dac,
    input  logic [VOL_W-1:0] noi_dac,
    input  logic [DLT_W-1:0] dlt_dac,
    output logic [DW-1:0]    rdata,
    output logic             rd_valid
);
    logic [DW-1:0] packed_word;

    // Form the word for the selected offset; zero when nothing selected.
    always_comb begin
        packed_word = '0;
        unique case (rd_sel)
            RSEL_SQ: packed_word = {sq2_dac, sq1_dac};
            RSEL_NT: packed_word = {noi_dac, tri_dac};
            RSEL_DS: packed_word = DW'(dlt_dac);
            default: packed_word = '0;
        endcase
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rdata    <= packed_word;
            rd_valid <= (rd_sel != RSEL_NONE);
        end
    end

    p_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_sel != RSEL_NONE));
    p_valid_needs_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(test_en));
    p_ds_msb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_sel == RSEL_DS) |-> !rdata[DW-1]);
endmodule

// File: rtl/snd_tm_ctrl.sv
// Control register: holds the lock flag and the forced triangle step,
// and emits a one-cycle load strobe on each diagnostic write.
module snd_tm_ctrl
    import snd_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DW-1:0]     wdata,
    output logic [STEP_W-1:0] tri_step,
    output logic              tri_load,
    output logic              freeze
);
    // Capture step and lock on a diagnostic write; pulse the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_step <= '0;
            tri_load <= 1'b0;
            freeze   <= 1'b0;
        end else begin
            tri_load <= wr_hit;
            if (wr_hit) begin
                tri_step <= wdata[STEP_W-1:0];
                freeze   <= wdata[LOCK_BIT];
            end
        end
    end

    p_load_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tri_load |-> $past(wr_hit));
    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_hit)) |-> ($stable(freeze) && $stable(tri_step)));
endmodule

// File: rtl/snd_tm_regwin.sv
// Top: diagnostic register window of the sound unit. Ties the decoder,
// read path and control register together and gates the bus clock while
// reset is held. Assumes rst_n is the same reset the CPU core sees.
module snd_tm_regwin
    import snd_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              m2_src,
    input  logic              page_sel,
    input  logic [AW-1:0]     addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic [VOL_W-1:0]  sq1_dac,
    input  logic [VOL_W-1:0]  sq2_dac,
    input  logic [VOL_W-1:0]  tri_dac,
    input  logic [VOL_W-1:0]  noi_dac,
    input  logic [DLT_W-1:0]  dlt_dac,
    output logic [DW-1:0]     rdata,
    output logic              rd_valid,
    output logic              bus_isolate,
    output logic [STEP_W-1:0] tri_step,
    output logic              tri_load,
    output logic              freeze,
    output logic              m2_out
);
    rsel_e rd_sel;
    logic  wr_hit;

    snd_tm_decode u_dec (
        .test_en (test_en),
        .page_sel(page_sel),
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rd_sel  (rd_sel),
        .wr_hit  (wr_hit),
        .isolate (bus_isolate)
    );

    snd_tm_rdmux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .rd_sel  (rd_sel),
        .sq1_dac (sq1_dac),
        .sq2_dac (sq2_dac),
        .tri_dac (tri_dac),
        .noi_dac (noi_dac),
        .dlt_dac (dlt_dac),
        .rdata   (rdata),
        .rd_valid(rd_valid)
    );

    snd_tm_ctrl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (wdata),
        .tri_step(tri_step),
        .tri_load(tri_load),
        .freeze  (freeze)
    );

    // Bus clock keeps running in reset only when test mode is on.
    always_comb begin
        m2_out = m2_src && (rst_n || test_en);
    end

    always_comb begin
        if (!rst_n && !test_en) p_m2_stopped_r8: assert (!m2_out);
        if (page_sel && rd_en && test_en) p_page_isolated_r6: assert (bus_isolate);
    end

    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (!freeze && !tri_load && !rd_valid && tri_step == '0));
endmodule

// File: tb/snd_tm_regwin_test.sv
// Bench: seeded random bus traffic plus directed corners, checked against
// an independent model of the requirements.
module snd_tm_regwin_test;
    logic       clk = 1'b0;
    logic       rst_n, test_en, m2_src, page_sel, rd_en, wr_en;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic [3:0] sq1_dac, sq2_dac, tri_dac, noi_dac;
    logic [6:0] dlt_dac;
    logic [7:0] rdata;
    logic       rd_valid, bus_isolate, tri_load, freeze, m2_out;
    logic [4:0] tri_step;

    int total = 0;
    int bad   = 0;

    // Model state (expected registered outputs).
    logic [7:0] e_rdata;
    logic       e_valid, e_load, e_freeze;
    logic [4:0] e_step;

    always #2.5 clk = ~clk;

    snd_tm_regwin uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .m2_src(m2_src),
        .page_sel(page_sel), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .sq1_dac(sq1_dac), .sq2_dac(sq2_dac),
        .tri_dac(tri_dac), .noi_dac(noi_dac), .dlt_dac(dlt_dac),
        .rdata(rdata), .rd_valid(rd_valid), .bus_isolate(bus_isolate),
        .tri_step(tri_step), .tri_load(tri_load), .freeze(freeze),
        .m2_out(m2_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic f_iso(logic ps, logic rd, logic te, logic [4:0] a);
        return ps && rd && (te || a == 5'h15);
    endfunction

    function automatic logic [7:0] f_word(logic [4:0] a);
        case (a)
            5'h18:   return {sq2_dac, sq1_dac};
            5'h19:   return {noi_dac, tri_dac};
            5'h1A:   return {1'b0, dlt_dac};
            default: return 8'h00;
        endcase
    endfunction

    // Check registered outputs against the model (call at negedge).
    task automatic chk_regs(input string tag);
        chk({tag, " R1 R2 R3 rdata"}, rdata, e_rdata);
        chk({tag, " R7 rd_valid"}, rd_valid, e_valid);
        chk({tag, " R4 tri_load"}, tri_load, e_load);
        chk({tag, " R4 freeze"}, freeze, e_freeze);
        chk({tag, " R4 tri_step"}, tri_step, e_step);
    endtask

    // Combinational checks, then advance the model for the next edge.
    task automatic apply_and_model();
        logic rhit;
        logic whit;
        #1;
        chk("R5 R6 bus_isolate", bus_isolate, f_iso(page_sel, rd_en, test_en, addr));
        chk("R8 m2_out", m2_out, m2_src && (rst_n || test_en));
        rhit = page_sel && rd_en && test_en && addr inside {5'h18, 5'h19, 5'h1A};
        whit = page_sel && wr_en && test_en && addr == 5'h1A;
        if (!rst_n) begin
            e_rdata = 0; e_valid = 0; e_load = 0; e_freeze = 0; e_step = 0;
        end else begin
            e_rdata = rhit ? f_word(addr) : 8'h00;
            e_valid = rhit;
            e_load  = whit;
            if (whit) begin
                e_freeze = wdata[7];
                e_step   = wdata[4:0];
            end
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic r, input logic te, input logic ps,
                         input logic [4:0] a, input logic rd, input logic wr,
                         input logic [7:0] d);
        rst_n = r; test_en = te; page_sel = ps; addr = a;
        rd_en = rd; wr_en = wr; wdata = d;
        m2_src  = 1'($urandom);
        sq1_dac = 4'($urandom); sq2_dac = 4'($urandom);
        tri_dac = 4'($urandom); noi_dac = 4'($urandom);
        dlt_dac = 7'($urandom);
        apply_and_model();
        chk_regs("cyc");
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R9: reset state
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 1, 5'h1A, 0, 1, 8'hFF);  // write during reset ignored, R9
        // R4: write with bits 6:5 set must not leak into step
        drive(1, 1, 1, 5'h1A, 0, 1, 8'hE3);
        drive(1, 1, 1, 5'h1A, 1, 0, 8'h00);  // R3 read, load drops
        // R7: test off write ignored, reads give nothing
        drive(1, 0, 1, 5'h1A, 0, 1, 8'h05);
        drive(1, 0, 1, 5'h18, 1, 0, 8'h00);
        // R6: controller offsets both modes
        drive(1, 0, 1, 5'h16, 1, 0, 8'h00);
        drive(1, 1, 1, 5'h17, 1, 0, 8'h00);
        // R5: status offset isolates without test mode
        drive(1, 0, 1, 5'h15, 1, 0, 8'h00);
        // R10: no page select
        drive(1, 1, 0, 5'h1A, 1, 1, 8'h9F);
        // R1 R2 reads
        drive(1, 1, 1, 5'h18, 1, 0, 8'h00);
        drive(1, 1, 1, 5'h19, 1, 0, 8'h00);
        // R8 R9: reset held in test mode, clock keeps going
        drive(0, 1, 1, 5'h19, 1, 1, 8'h80);
        drive(0, 0, 0, 5'h00, 0, 0, 8'h00);
        // Random traffic: reads and writes may coincide
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a;
            a = ($urandom % 2) ? 5'(5'h15 + $urandom % 6) : 5'($urandom);
            drive(($urandom % 32) != 0, ($urandom % 4) != 0, ($urandom % 8) != 0,
                  a, 1'($urandom), 1'($urandom), 8'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule